// File: doc/BRIEF.md
# Multi-Lane I2S Serial Audio Transmitter

This block turns up to four stereo sample streams into serial audio on four data lanes. The lanes share one bit clock and one word-select line. The bit clock is divided down from the system clock. Each frame has a left slot followed by a right slot. Format inputs set the following:

- which bit-clock edge is the sampling edge
- the slot width
- the word-select polarity
- justification inside the slot
- bit order
- whether word select leads the data by one bit

Each lane picks its source stream through a 2-bit map and can exchange left and right. It can be disabled or muted. Samples carry 24 audio bits plus four status bits. The status bits can be appended to form a 28-bit payload. An incoming word-length code, or an override code, zeroes the audio bits below the valid length.

All format, lane and length settings and all sample words are captured while the run input is low, and again at each frame start. A change made in the middle of a frame is therefore deferred to the next frame. With run low, every output sits at 0.

Top module: `i2s_tx`

## Requirements
- R1: While `run_i` is 0, `sck_o`, `ws_o` and every bit of `sd_o` are 0, and settings and samples are captured each clock.
- R2: `edge_fall_i`=0 makes the rising edge of `sck_o` the sampling edge, with data changing on the falling edge. `edge_fall_i`=1 inverts `sck_o`, so the falling edge samples. `sd_o` and `ws_o` never change at a sampling edge.
- R3: `slot16_i`=1 gives 16-bit slots and `slot16_i`=0 gives 32-bit slots. A frame is two slots, left first, and bit positions run 0..2S-1 without gaps while running.
- R4: With `ws_pol_i`=0, `ws_o` is low while left bits are carried; with `ws_pol_i`=1, it is high for left.
- R5: With `no_delay_i`=0, `ws_o` changes one bit period before the first bit of each slot. With `no_delay_i`=1, it changes together with that first bit.
- R6: The payload is 24 audio bits. With `vucp_en_i`=1 it is 28 bits: the audio word followed by the status nibble, bit 3 of the nibble first in MSB order. A slot carries the top min(payload, S) bits. `just_right_i`=0 puts them at the start of the slot and `just_right_i`=1 puts them at its end. All other slot bits are 0.
- R7: `lsb_first_i`=0 sends the carried field MSB first; `lsb_first_i`=1 sends it LSB first.
- R8: Lane l sends stream `lane_map_i[2l+1:2l]` (stream s occupies `smp_*_i[24s+23:24s]` and `vu_*_i[4s+3:4s]`).
- R9: `lane_swap_i[l]`=1 puts the right sample in the left slot and the left sample in the right slot of lane l.
- R10: A lane with `lane_en_i[l]`=0 outputs constant 0.
- R11: The length code c (`len_ovr_i` when `len_ovr_en_i`=1, otherwise `len_i`) gives 16+c valid audio bits for c<8 and 24 bits otherwise. Audio bits below that length are sent as 0.
- R12: A lane with `lane_mute_i[l]`=1 sends all-zero slots while `sck_o` and `ws_o` keep running.
- R13: Changes to settings or samples made while running take effect at the next frame start, never inside the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1: serialize; 0: outputs low |
| edge_fall_i | input | 1 | Sampling edge select |
| slot16_i | input | 1 | 1: 16-bit slots, 0: 32-bit slots |
| ws_pol_i | input | 1 | Word-select level for left |
| just_right_i | input | 1 | Right-justify payload in slot |
| lsb_first_i | input | 1 | Send LSB first |
| no_delay_i | input | 1 | Remove the one-bit WS lead |
| vucp_en_i | input | 1 | Append status nibble (28-bit payload) |
| len_ovr_en_i | input | 1 | Use override length code |
| len_ovr_i | input | 4 | Override length code |
| len_i | input | 4 | Incoming length code |
| lane_en_i | input | N_LANE | Per-lane enable |
| lane_map_i | input | N_LANE*MAP_W | Per-lane stream select |
| lane_swap_i | input | N_LANE | Per-lane left/right exchange |
| lane_mute_i | input | N_LANE | Per-lane mute |
| smp_l_i | input | N_STREAM*24 | Left audio words |
| smp_r_i | input | N_STREAM*24 | Right audio words |
| vu_l_i | input | N_STREAM*4 | Left status nibbles |
| vu_r_i | input | N_STREAM*4 | Right status nibbles |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | N_LANE | Serial data lanes |

## Verification
The bench decodes whole frames on every lane and checks them against a model built from the requirements. One frame combines right justification, LSB-first order, the 16-bit slot, no lead and the falling sampling edge. This catches an off-by-one offset or a reversed index: such a design would shift or mirror the carried field and leak bits into the zero fill. Other frames use reversed stream maps, swapped lanes, a disabled lane and a muted lane, so a crossed map or a mute that also stopped the clocks shows up as wrong data or missing edges. A frame pair with new settings applied mid-frame exposes a design that latches early: it would corrupt the tail of the first frame. Length codes are tried both with and without the override, which catches a wrong choice between them through the number of zeroed low audio bits.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
  localparam int DATA_W   = 24;
  localparam int VU_W     = 4;
  localparam int PL_W     = DATA_W + VU_W;
  localparam int SLOT_MAX = 32;
  localparam int SLOT_MIN = 16;

  typedef struct packed {
    logic edge_fall;
    logic slot16;
    logic ws_pol;
    logic just_right;
    logic lsb_first;
    logic no_delay;
    logic vucp_en;
  } fmt_t;

  // bit carried at slot position k for payload pl
  function automatic logic slot_bit(input logic [PL_W-1:0] pl, input fmt_t f,
                                    input logic [4:0] k);
    int w, s, n, o, j, idx;
    logic [4:0] ix;
    w = f.vucp_en ? PL_W : DATA_W;
    s = f.slot16 ? SLOT_MIN : SLOT_MAX;
    n = (w < s) ? w : s;
    o = f.just_right ? s - n : 0;
    j = int'(k) - o;
    if (j < 0 || j >= n) return 1'b0;
    idx = f.lsb_first ? (w - n + j) : (w - 1 - j);
    ix  = idx[4:0];
    return pl[ix];
  endfunction

  // keep mask for the valid audio bits of a length code
  function automatic logic [DATA_W-1:0] len_mask(input logic [3:0] code);
    int nv;
    logic [DATA_W-1:0] m;
    nv = (code >= 4'd8) ? DATA_W : SLOT_MIN + int'(code);
    for (int i = 0; i < DATA_W; i++) m[i] = (i >= DATA_W - nv);
    return m;
  endfunction
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int HALF_DIV = 2,
  parameter int POS_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             slot16_i,
  output logic             ph_o,
  output logic [POS_W-1:0] pos_o,
  output logic [POS_W-1:0] last_o,
  output logic             tick_o
);
  import i2s_tx_pkg::*;
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic             ph_q;
  logic [POS_W-1:0] pos_q;
  logic             half_end;

  assign last_o   = slot16_i ? POS_W'(2*SLOT_MIN - 1) : POS_W'(2*SLOT_MAX - 1);
  assign half_end = (div_q == DIV_END);
  assign tick_o   = run_i && half_end && ph_q && (pos_q == last_o);
  assign ph_o     = ph_q;
  assign pos_o    = pos_q;

  // ph 0->1: sampling point, ph 1->0: launch of next bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ph_q  <= 1'b0;
      pos_q <= '0;
    end else if (!run_i) begin
      div_q <= '0;
      ph_q  <= 1'b0;
      pos_q <= '0;
    end else if (half_end) begin
      div_q <= '0;
      ph_q  <= ~ph_q;
      if (ph_q) pos_q <= (pos_q == last_o) ? '0 : pos_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_tx_lane.sv
module i2s_tx_lane #(
  parameter int N_STREAM = 4,
  parameter int MAP_W    = 2,
  parameter int POS_W    = 6
) (
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      load_i,
  input  logic [N_STREAM*i2s_tx_pkg::DATA_W-1:0]    smp_l_i,
  input  logic [N_STREAM*i2s_tx_pkg::DATA_W-1:0]    smp_r_i,
  input  logic [N_STREAM*i2s_tx_pkg::VU_W-1:0]      vu_l_i,
  input  logic [N_STREAM*i2s_tx_pkg::VU_W-1:0]      vu_r_i,
  input  logic [MAP_W-1:0]                          map_i,
  input  logic                                      swap_i,
  input  logic                                      en_i,
  input  logic                                      mute_i,
  input  logic                                      vucp_en_i,
  input  logic [i2s_tx_pkg::DATA_W-1:0]             mask_i,
  input  i2s_tx_pkg::fmt_t                          fmt_i,
  input  logic [POS_W-1:0]                          pos_i,
  output logic                                      sd_o
);
  import i2s_tx_pkg::*;

  logic [DATA_W-1:0] d_l, d_r;
  logic [VU_W-1:0]   v_l, v_r;
  logic [PL_W-1:0]   pl_l_d, pl_r_d, pl_l_q, pl_r_q;
  logic              en_q, mute_q, right;
  logic [4:0]        k;

  assign d_l = smp_l_i[map_i*DATA_W +: DATA_W] & mask_i;
  assign d_r = smp_r_i[map_i*DATA_W +: DATA_W] & mask_i;
  assign v_l = vu_l_i[map_i*VU_W +: VU_W];
  assign v_r = vu_r_i[map_i*VU_W +: VU_W];

  always_comb begin
    pl_l_d = vucp_en_i ? {d_l, v_l} : {{VU_W{1'b0}}, d_l};
    pl_r_d = vucp_en_i ? {d_r, v_r} : {{VU_W{1'b0}}, d_r};
    if (swap_i) begin
      pl_l_d = vucp_en_i ? {d_r, v_r} : {{VU_W{1'b0}}, d_r};
      pl_r_d = vucp_en_i ? {d_l, v_l} : {{VU_W{1'b0}}, d_l};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pl_l_q <= '0;
      pl_r_q <= '0;
      en_q   <= 1'b0;
      mute_q <= 1'b0;
    end else if (load_i) begin
      pl_l_q <= pl_l_d;
      pl_r_q <= pl_r_d;
      en_q   <= en_i;
      mute_q <= mute_i;
    end
  end

  always_comb begin
    if (fmt_i.slot16) begin
      right = (pos_i >= POS_W'(SLOT_MIN));
      k     = 5'(pos_i - (right ? POS_W'(SLOT_MIN) : '0));
    end else begin
      right = (pos_i >= POS_W'(SLOT_MAX));
      k     = 5'(pos_i - (right ? POS_W'(SLOT_MAX) : '0));
    end
  end

  assign sd_o = en_q && !mute_q && slot_bit(right ? pl_r_q : pl_l_q, fmt_i, k);
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int N_LANE   = 4,
  parameter int N_STREAM = 4,
  parameter int HALF_DIV = 2,
  localparam int MAP_W   = (N_STREAM > 1) ? $clog2(N_STREAM) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_i,
  input  logic                         edge_fall_i,
  input  logic                         slot16_i,
  input  logic                         ws_pol_i,
  input  logic                         just_right_i,
  input  logic                         lsb_first_i,
  input  logic                         no_delay_i,
  input  logic                         vucp_en_i,
  input  logic                         len_ovr_en_i,
  input  logic [3:0]                   len_ovr_i,
  input  logic [3:0]                   len_i,
  input  logic [N_LANE-1:0]            lane_en_i,
  input  logic [N_LANE*MAP_W-1:0]      lane_map_i,
  input  logic [N_LANE-1:0]            lane_swap_i,
  input  logic [N_LANE-1:0]            lane_mute_i,
  input  logic [N_STREAM*DATA_W-1:0]   smp_l_i,
  input  logic [N_STREAM*DATA_W-1:0]   smp_r_i,
  input  logic [N_STREAM*VU_W-1:0]     vu_l_i,
  input  logic [N_STREAM*VU_W-1:0]     vu_r_i,
  output logic                         sck_o,
  output logic                         ws_o,
  output logic [N_LANE-1:0]            sd_o
);
  localparam int POS_W = $clog2(2*SLOT_MAX);

  fmt_t              fmt_d, fmt_q;
  logic              ph_q, frame_tick, load, ws_left;
  logic [POS_W-1:0]  pos_q, pos_last;
  logic [POS_W:0]    ws_pos;
  logic [DATA_W-1:0] mask;
  logic [N_LANE-1:0] sd_raw;

  assign fmt_d = '{edge_fall: edge_fall_i, slot16: slot16_i, ws_pol: ws_pol_i,
                   just_right: just_right_i, lsb_first: lsb_first_i,
                   no_delay: no_delay_i, vucp_en: vucp_en_i};
  assign load  = !run_i || frame_tick;
  assign mask  = len_mask(len_ovr_en_i ? len_ovr_i : len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fmt_q <= '0;
    else if (load) fmt_q <= fmt_d;
  end

  i2s_tx_clkgen #(.HALF_DIV(HALF_DIV), .POS_W(POS_W)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .slot16_i(fmt_q.slot16),
    .ph_o    (ph_q),
    .pos_o   (pos_q),
    .last_o  (pos_last),
    .tick_o  (frame_tick)
  );

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    i2s_tx_lane #(.N_STREAM(N_STREAM), .MAP_W(MAP_W), .POS_W(POS_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .smp_l_i  (smp_l_i),
      .smp_r_i  (smp_r_i),
      .vu_l_i   (vu_l_i),
      .vu_r_i   (vu_r_i),
      .map_i    (lane_map_i[l*MAP_W +: MAP_W]),
      .swap_i   (lane_swap_i[l]),
      .en_i     (lane_en_i[l]),
      .mute_i   (lane_mute_i[l]),
      .vucp_en_i(vucp_en_i),
      .mask_i   (mask),
      .fmt_i    (fmt_q),
      .pos_i    (pos_q),
      .sd_o     (sd_raw[l])
    );
  end

  // WS leads the slot by one bit unless the delay is removed
  always_comb begin
    ws_pos = {1'b0, pos_q} + ((POS_W+1)'(!fmt_q.no_delay));
    if (ws_pos > {1'b0, pos_last}) ws_pos = '0;
    ws_left = fmt_q.slot16 ? (ws_pos < (POS_W+1)'(SLOT_MIN))
                           : (ws_pos < (POS_W+1)'(SLOT_MAX));
  end

  assign sck_o = run_i && (fmt_q.edge_fall ? !ph_q : ph_q);
  assign ws_o  = run_i && (fmt_q.ws_pol ? ws_left : !ws_left);
  assign sd_o  = run_i ? sd_raw : '0;
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int N_LANE = 4,
  parameter int POS_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              sck_o,
  input logic              ws_o,
  input logic [N_LANE-1:0] sd_o,
  input logic              ph_q,
  input logic [POS_W-1:0]  pos_q,
  input logic [POS_W-1:0]  pos_last
);
  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!sck_o && !ws_o && sd_o == '0));

  assert_stable_at_sample_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $rose(ph_q)) |-> ($stable(sd_o) && $stable(ws_o)));

  assert_pos_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pos_q <= pos_last));

  assert_pos_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && pos_q != $past(pos_q)) |->
      (pos_q == $past(pos_q) + 1'b1) || (pos_q == '0 && $past(pos_q) == $past(pos_last)));

  assert_ws_moves_with_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && ws_o != $past(ws_o)) |-> (pos_q != $past(pos_q)));
endmodule

bind i2s_tx i2s_tx_chk #(.N_LANE(N_LANE), .POS_W(POS_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .sck_o   (sck_o),
  .ws_o    (ws_o),
  .sd_o    (sd_o),
  .ph_q    (ph_q),
  .pos_q   (pos_q),
  .pos_last(pos_last)
);

// File: tb/i2s_tx_tb.sv
module i2s_tx_tb;
  typedef struct packed {
    logic edge_fall, slot16, ws_pol, just_right, lsb_first, no_delay, vucp_en, ovr_en;
    logic [3:0] ovr, len, en;
    logic [7:0] map;
    logic [3:0] swap, mute;
    logic [3:0][23:0] dl, dr;
    logic [3:0][3:0] vl, vr;
  } tcase_t;

  typedef struct packed {
    logic slot16, edge_fall;
    logic [3:0][63:0] sd;
    logic [63:0] ws;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic edge_fall, slot16, ws_pol, just_right, lsb_first, no_delay, vucp_en, ovr_en;
  logic [3:0] ovr, len, en, swap, mute;
  logic [7:0] map;
  logic [95:0] sl, sr;
  logic [15:0] vl, vr;
  logic sck, ws;
  logic [3:0] sd;
  int total = 0, bad = 0;
  exp_t exq[$];
  string tgq[$];

  always #2 clk = ~clk;

  i2s_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .edge_fall_i(edge_fall), .slot16_i(slot16),
    .ws_pol_i(ws_pol), .just_right_i(just_right), .lsb_first_i(lsb_first),
    .no_delay_i(no_delay), .vucp_en_i(vucp_en), .len_ovr_en_i(ovr_en), .len_ovr_i(ovr),
    .len_i(len), .lane_en_i(en), .lane_map_i(map), .lane_swap_i(swap), .lane_mute_i(mute),
    .smp_l_i(sl), .smp_r_i(sr), .vu_l_i(vl), .vu_r_i(vr),
    .sck_o(sck), .ws_o(ws), .sd_o(sd)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input tcase_t t);
    exp_t e;
    int s, w, n, off, code, nv, st, j, idx, d;
    logic right, use_r;
    logic [23:0] a;
    logic [27:0] pl;
    e = '0;
    e.slot16 = t.slot16;
    e.edge_fall = t.edge_fall;
    s = t.slot16 ? 16 : 32;
    w = t.vucp_en ? 28 : 24;
    n = (w < s) ? w : s;
    off = t.just_right ? s - n : 0;
    code = t.ovr_en ? int'(t.ovr) : int'(t.len);
    nv = (code >= 8) ? 24 : 16 + code;
    d = t.no_delay ? 0 : 1;
    for (int p = 0; p < 2*s; p++) begin
      e.ws[p] = t.ws_pol ? (((p + d) % (2*s)) < s) : !(((p + d) % (2*s)) < s);
      right = (p >= s);
      j = (right ? p - s : p) - off;
      for (int l = 0; l < 4; l++) begin
        st = int'(t.map[2*l +: 2]);
        use_r = right ^ t.swap[l];
        a = use_r ? t.dr[st] : t.dl[st];
        a = (a >> (24 - nv)) << (24 - nv);
        pl = t.vucp_en ? {a, (use_r ? t.vr[st] : t.vl[st])} : {4'h0, a};
        idx = t.lsb_first ? (w - n + j) : (w - 1 - j);
        if (t.en[l] && !t.mute[l] && j >= 0 && j < n) e.sd[l][p] = pl[idx];
      end
    end
    return e;
  endfunction

  task automatic apply(input tcase_t t);
    edge_fall = t.edge_fall; slot16 = t.slot16; ws_pol = t.ws_pol; just_right = t.just_right;
    lsb_first = t.lsb_first; no_delay = t.no_delay; vucp_en = t.vucp_en; ovr_en = t.ovr_en;
    ovr = t.ovr; len = t.len; en = t.en; map = t.map; swap = t.swap; mute = t.mute;
    sl = t.dl; sr = t.dr; vl = t.vl; vr = t.vr;
  endtask

  task automatic run_one(input tcase_t t, input string tag);
    @(negedge clk); apply(t);
    repeat (2) @(negedge clk);
    exq.push_back(model(t)); tgq.push_back(tag);
    run = 1'b1;
    wait (exq.size() == 0);
    @(negedge clk); run = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor: collects one frame per expected item
  initial begin
    exp_t cur, got;
    string tg;
    int n;
    forever begin
      wait (exq.size() != 0);
      cur = exq[0]; tg = tgq[0];
      n = cur.slot16 ? 32 : 64;
      got = '0;
      for (int p = 0; p < n; p++) begin
        if (cur.edge_fall) @(negedge sck); else @(posedge sck);
        #1;
        got.ws[p] = ws;
        for (int l = 0; l < 4; l++) got.sd[l][p] = sd[l];
      end
      for (int l = 0; l < 4; l++)
        chk(got.sd[l] === cur.sd[l], $sformatf("%s lane%0d", tg, l), got.sd[l], cur.sd[l]);
      chk(got.ws === cur.ws, {tg, " ws"}, got.ws, cur.ws);
      void'(exq.pop_front()); void'(tgq.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tcase_t a, b;
    a = '0;
    a.len = 4'd8; a.en = 4'hF; a.map = 8'b11_10_01_00;
    for (int s = 0; s < 4; s++) begin
      a.dl[s] = 24'hA5C3F0 ^ (24'h111111 * (s + 1));
      a.dr[s] = 24'h3C96E7 ^ (24'h0F0F0F * (s + 1));
      a.vl[s] = 4'(4'h9 + s);
      a.vr[s] = 4'(4'h6 ^ s);
    end
    apply(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 idle state after reset
    chk(sck === 1'b0, "R1 sck idle", 64'(sck), 0);
    chk(ws === 1'b0, "R1 ws idle", 64'(ws), 0);
    chk(sd === 4'h0, "R1 sd idle", 64'(sd), 0);

    // R3 R4 R5 R6 R7 R8 R2: 32-bit, left justified, MSB first, delayed WS
    run_one(a, "R2 R3 R4 R5 R6 R7 R8 base");

    // R2 R3 R4 R5 R6 R7: 16-bit, right justified, LSB first, no delay, falling edge, pol 1
    b = a;
    b.edge_fall = 1; b.slot16 = 1; b.ws_pol = 1; b.just_right = 1; b.lsb_first = 1; b.no_delay = 1;
    run_one(b, "R2 R3 R4 R5 R6 R7 alt");

    // R6 R8 R9 R11: status bits, right justified in 32, reversed map, swaps, 20-bit length
    b = a;
    b.vucp_en = 1; b.just_right = 1; b.map = 8'b00_01_10_11; b.swap = 4'b0101; b.len = 4'd4;
    run_one(b, "R6 R8 R9 R11 vucp");

    // R10 R11 R12: override length 16, disabled and muted lanes
    b = a;
    b.ovr_en = 1; b.ovr = 4'd0; b.en = 4'b1011; b.mute = 4'b0010; b.lsb_first = 1;
    run_one(b, "R10 R11 R12 ovr");

    // R13: settings changed mid-frame apply at next frame only
    b = a;
    b.slot16 = 1; b.map = 8'b01_00_11_10; b.just_right = 1; b.swap = 4'b1001;
    for (int s = 0; s < 4; s++) b.dl[s] = ~a.dl[s];
    @(negedge clk); apply(a);
    repeat (2) @(negedge clk);
    exq.push_back(model(a)); tgq.push_back("R13 first frame");
    exq.push_back(model(b)); tgq.push_back("R13 second frame");
    run = 1'b1;
    repeat (10) @(posedge sck);
    @(negedge clk); apply(b);
    wait (exq.size() == 0);
    @(negedge clk); run = 1'b0;
    repeat (2) @(negedge clk);
    // R1 outputs low again once stopped
    chk({sck, ws, sd} === 6'h0, "R1 stop idle", 64'({sck, ws, sd}), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule